// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

The block is an up-counter built from identical 4-bit slices that share one rising clock edge. Every state bit changes on that edge, so there is no skew between output bits. The inputs are:

- an active-low clear;
- an active-low parallel load;
- two active-high count enables, P and T.

Only T goes forward into the terminal-count carry. That lets a carry from one counter enable the next counter directly, with no extra gating.

Inside the top, `NUM_STAGES` slices of `STAGE_W` bits each form one wide counter. Every slice gets the common P enable. A slice's T is the terminal carry of the slice below it. That carry is formed either by a stage-to-stage chain or by a lookahead AND of all lower slices, selected by a parameter. The two options give identical results.

Clear and load are both synchronous and override the enables. A modulo-N counter is therefore made by decoding one state externally and feeding it back into the clear input.

Top module: `sync_bin_counter`

## Requirements
- R1: When `clear_n` is low at a rising clock edge, `count` becomes 0 at that edge, whatever `load_n`, the enables and `load_val` are. Between edges, lowering `clear_n` leaves `count` unchanged.
- R2: When `clear_n` is high and `load_n` is low at a rising edge, `count` takes `load_val`, whatever the enables are.
- R3: When `clear_n` and `load_n` are high and both `cnt_en_p` and `cnt_en_t` are high, `count` increments by one at the edge.
- R4: When `clear_n` and `load_n` are high and either enable is low, `count` holds its value.
- R5: `carry_o` is high exactly when `cnt_en_t` is high and `count` is all ones. It follows both of these within the same cycle, with no register in the path.
- R6: An increment from all ones wraps `count` to 0.
- R7: A slice above the lowest one changes on a counting edge only when all lower slices are all ones. Over 2^W consecutive counts, the full width visits every value in order. W is `STAGE_W*NUM_STAGES`, which is 8 with the default parameters.
- R8: If the decode of `count == 9` drives `clear_n` low, the counter repeats 0..9 and returns to 0 after the 9.
- R9: This sequence must work: clear, preset to 252, count through 253, 254, 255, 0, 1 and 2, then inhibit with the count held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all state bits |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en_p | input | 1 | Count enable P, shared by all slices |
| cnt_en_t | input | 1 | Count enable T, also gates the carry |
| load_val | input | STAGE_W*NUM_STAGES | Value taken on a load |
| count | output | STAGE_W*NUM_STAGES | Counter state |
| carry_o | output | 1 | Terminal-count carry for cascading |

## Verification
The bench goes after the priority corners:

- Clear asserted together with load and data. A design that ranked load above clear would end up holding the data.
- Load with both enables low. A design that gated load with the enables would keep the old count.
- A count with only P or only T high. A wrong enable term would increment the count.

Wrapping through 255 checks that the upper slice advances only on the lower slice's terminal count, and that the carry appears during the all-ones cycle, not one cycle later. The decoded modulo-10 loop and the preset-count-inhibit sequence catch a clear that acts without a clock edge, or a carry taken from P instead of T.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

   typedef enum logic [1:0] {
      SBC_HOLD  = 2'd0,
      SBC_CLEAR = 2'd1,
      SBC_LOAD  = 2'd2,
      SBC_COUNT = 2'd3
   } sbc_op_e;

   // Edge action: clear over load over count over hold.
   function automatic sbc_op_e sbc_pick_op(input logic clear_n, input logic load_n,
                                           input logic en_p, input logic en_t);
      if (!clear_n)           return SBC_CLEAR;
      else if (!load_n)       return SBC_LOAD;
      else if (en_p && en_t)  return SBC_COUNT;
      else                    return SBC_HOLD;
   endfunction

endpackage

// File: rtl/sbc_slice.sv
module sbc_slice
   import sbc_pkg::*;
#(
   parameter int SLICE_W = 4
) (
   input  logic               clk,
   input  logic               clear_n,
   input  logic               load_n,
   input  logic               en_p,
   input  logic               en_t,
   input  logic [SLICE_W-1:0] din,
   output logic [SLICE_W-1:0] q,
   output logic               full_o
);

   localparam logic [SLICE_W-1:0] ONE = SLICE_W'(1);

   if (SLICE_W < 1) begin : g_bad_w
      $error("sbc_slice: SLICE_W must be at least 1");
   end

   sbc_op_e             op;
   logic [SLICE_W-1:0]  q_nxt;

   always_comb begin
      op = sbc_pick_op(clear_n, load_n, en_p, en_t);
      unique case (op)
         SBC_CLEAR: q_nxt = '0;
         SBC_LOAD:  q_nxt = din;
         SBC_COUNT: q_nxt = q + ONE;
         default:   q_nxt = q;
      endcase
   end

   always_ff @(posedge clk) q <= q_nxt;

   assign full_o = &q;

   // Checks become live once a clear has defined the state.
   logic chk_live = 1'b0;
   always_ff @(posedge clk) if (!clear_n) chk_live <= 1'b1;

   a_r1_clear: assert property (@(posedge clk) disable iff (!chk_live)
      !clear_n |=> q == '0);
   a_r2_load: assert property (@(posedge clk) disable iff (!chk_live)
      (clear_n && !load_n) |=> q == $past(din));
   a_r3_count: assert property (@(posedge clk) disable iff (!chk_live)
      (clear_n && load_n && en_p && en_t) |=> q == SLICE_W'($past(q) + ONE));
   a_r4_hold: assert property (@(posedge clk) disable iff (!chk_live)
      (clear_n && load_n && !(en_p && en_t)) |=> $stable(q));

endmodule

// File: rtl/sbc_carry_net.sv
module sbc_carry_net #(
   parameter int NUM_STAGES = 2,
   parameter bit LOOKAHEAD  = 1'b0
) (
   input  logic                  en_t,
   input  logic [NUM_STAGES-1:0] full,
   output logic [NUM_STAGES-1:0] stage_t,
   output logic                  carry_o
);

   if (NUM_STAGES < 1) begin : g_bad_n
      $error("sbc_carry_net: NUM_STAGES must be at least 1");
   end

   assign stage_t[0] = en_t;

   for (genvar i = 1; i < NUM_STAGES; i++) begin : g_t
      if (LOOKAHEAD) begin : g_la
         // One wide AND: flat depth, more fan-in per stage.
         assign stage_t[i] = en_t & (&full[i-1:0]);
      end else begin : g_rip
         // Each stage's carry feeds the next stage's T.
         assign stage_t[i] = stage_t[i-1] & full[i-1];
      end
   end

   assign carry_o = stage_t[NUM_STAGES-1] & full[NUM_STAGES-1];

endmodule

// File: rtl/sync_bin_counter.sv
module sync_bin_counter #(
   parameter int STAGE_W    = 4,
   parameter int NUM_STAGES = 2,
   parameter bit LOOKAHEAD  = 1'b0
) (
   input  logic                          clk,
   input  logic                          clear_n,
   input  logic                          load_n,
   input  logic                          cnt_en_p,
   input  logic                          cnt_en_t,
   input  logic [STAGE_W*NUM_STAGES-1:0] load_val,
   output logic [STAGE_W*NUM_STAGES-1:0] count,
   output logic                          carry_o
);

   localparam int TOT_W = STAGE_W * NUM_STAGES;

   if (STAGE_W < 1 || STAGE_W > 32) begin : g_bad_sw
      $error("sync_bin_counter: STAGE_W out of range 1..32");
   end
   if (NUM_STAGES < 1 || TOT_W > 64) begin : g_bad_ns
      $error("sync_bin_counter: NUM_STAGES out of range");
   end

   logic [NUM_STAGES-1:0] full;
   logic [NUM_STAGES-1:0] stage_t;

   for (genvar s = 0; s < NUM_STAGES; s++) begin : g_slice
      sbc_slice #(.SLICE_W(STAGE_W)) slice_i (
         .clk     (clk),
         .clear_n (clear_n),
         .load_n  (load_n),
         .en_p    (cnt_en_p),
         .en_t    (stage_t[s]),
         .din     (load_val[s*STAGE_W +: STAGE_W]),
         .q       (count[s*STAGE_W +: STAGE_W]),
         .full_o  (full[s])
      );
   end

   sbc_carry_net #(.NUM_STAGES(NUM_STAGES), .LOOKAHEAD(LOOKAHEAD)) carry_i (
      .en_t    (cnt_en_t),
      .full    (full),
      .stage_t (stage_t),
      .carry_o (carry_o)
   );

   logic chk_live = 1'b0;
   always_ff @(posedge clk) if (!clear_n) chk_live <= 1'b1;

   a_r5_carry: assert property (@(posedge clk) disable iff (!chk_live)
      carry_o == (cnt_en_t && count == {TOT_W{1'b1}}));
   a_r6_wrap: assert property (@(posedge clk) disable iff (!chk_live)
      (clear_n && load_n && cnt_en_p && cnt_en_t && count == {TOT_W{1'b1}})
      |=> count == '0);

   for (genvar s = 1; s < NUM_STAGES; s++) begin : g_chk_up
      a_r7_upper_hold: assert property (@(posedge clk) disable iff (!chk_live)
         (clear_n && load_n && !(cnt_en_p && cnt_en_t && count[s*STAGE_W-1:0] == {(s*STAGE_W){1'b1}}))
         |=> $stable(count[s*STAGE_W +: STAGE_W]));
   end

endmodule

// File: tb/sync_bin_counter_tb_top.sv
module sync_bin_counter_tb_top;

   localparam int W   = 8;
   localparam int MAX = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         clear_n = 1'b1, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
   logic [W-1:0] load_val = '0;
   logic [W-1:0] count;
   logic         carry_o;

   always #5 clk = ~clk;

   sync_bin_counter #(.STAGE_W(4), .NUM_STAGES(2), .LOOKAHEAD(1'b0)) dut_i (
      .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en_p(en_p),
      .cnt_en_t(en_t), .load_val(load_val), .count(count), .carry_o(carry_o)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int ref_q  = 0;
   bit done   = 1'b0;

   task automatic chk(string tag, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   // One clock: drive at the falling edge, check the carry before the rising
   // edge, step the model at the edge, then check the count.
   task automatic step(bit c, bit l, bit p, bit t, int d, string ctag);
      int    prev;
      string tag;
      @(negedge clk);
      clear_n = c; load_n = l; en_p = p; en_t = t; load_val = W'(d);
      #1;
      chk("R5 carry", int'(carry_o), (t && ref_q == MAX) ? 1 : 0);
      if (!c) chk("R1 no change before edge", int'(count), ref_q);
      @(posedge clk);
      prev = ref_q;
      if (!c)          begin ref_q = 0;                 tag = "R1 clear"; end
      else if (!l)     begin ref_q = d & MAX;           tag = "R2 load";  end
      else if (p && t) begin
         ref_q = (ref_q + 1) & MAX;
         tag = (prev == MAX) ? "R6 wrap" : "R3 count";
         if (ctag != "") tag = ctag;
      end
      else             begin tag = "R4 hold"; end
      #2;
      chk(tag, int'(count), ref_q);
   endtask

   initial begin
      // Reset state: a clear with load, enables and data active (R1).
      step(0, 0, 1, 1, 8'hA5, "");
      // Load ignores enables (R2).
      step(1, 0, 0, 0, 8'h3C, "");
      step(1, 1, 1, 0, 0, "");       // R4 T low
      step(1, 1, 0, 1, 0, "");       // R4 P low
      step(1, 1, 1, 1, 0, "");       // R3
      step(1, 0, 1, 1, MAX, "");     // R2 load all ones while enabled
      step(1, 1, 0, 1, 0, "");       // R5 carry high with P low
      step(1, 1, 1, 1, 0, "");       // R6 wrap
      // Typical sequence (R9).
      step(0, 1, 0, 0, 0, "R9");
      step(1, 0, 0, 0, 252, "R9");
      for (int i = 0; i < 6; i++) step(1, 1, 1, 1, 0, "R9 count");
      for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0, "R9 inhibit");
      // Full-range cascade (R7).
      step(0, 1, 1, 1, 0, "");
      for (int i = 0; i < 2 * (MAX + 1) + 3; i++) step(1, 1, 1, 1, 0, "R7 cascade");
      // Modulo-10 by decoding 9 into the clear (R8).
      step(0, 1, 1, 1, 0, "");
      for (int i = 0; i < 40; i++) step((count == 9) ? 1'b0 : 1'b1, 1, 1, 1, 0, "R8 modulo");
      // Random mix.
      for (int i = 0; i < 2000; i++) begin
         bit c = ($urandom_range(0, 19) != 0);
         bit l = ($urandom_range(0, 9) != 0);
         bit p = ($urandom_range(0, 3) != 0);
         bit t = ($urandom_range(0, 3) != 0);
         step(c, l, p, t, int'($urandom_range(0, MAX)), "");
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(100000 * 10);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule